// File: doc/BRIEF.md
# Flash Status Busy-Wait Poller

This block sits between a flash command sequencer and the frame engine that drives the serial flash bus. After a read, program, erase or reset command has been sent to the device, the sequencer pulses `start` with the kind of operation. The poller then waits a settle time chosen for that operation. After that it asks the frame engine to read the device status register, and it checks the busy flag in the returned byte. While the device stays busy, it repeats the status read after a poll gap, which is also chosen per operation.

The wait ends in one of two ways. If a status byte comes back with the busy flag clear, that byte is reported. If the overall deadline passes while the device is still busy, the poller gives up and raises a timeout flag. All delays are given in microseconds and turned into clock cycles through a cycles-per-microsecond parameter.

Top module: `flash_busy_poller`

## Requirements
- R1: Every status request shows opcode 0x0F on `desc_opcode` and register address 0xC0 on `desc_regaddr` while `desc_valid` is high.
- R2: The settle time depends on `op_sel`: 0 is a read (6 us), 1 is a program (75 us), 2 is an erase (250 us) and 3 is a reset (5 us). `desc_valid` first rises exactly settle_us × CYC_PER_US cycles after the clock edge that accepts `start`.
- R3: When a response arrives with bit 0 of `rsp_byte` set (busy), `desc_valid` rises again exactly gap_us × CYC_PER_US cycles after the edge that accepts the response. The gap is 5 us for a read, 15 us for a program, 50 us for an erase and 5 us for a reset.
- R4: When a response arrives with bit 0 clear, `done` is high in the cycle after the edge that accepts it. `status_out` then equals that byte unchanged, and `timed_out` is 0.
- R5: The deadline is TIMEOUT_US × CYC_PER_US cycles, counted from the edge that accepts `start`, including the settle time. If the device is still busy when the deadline passes, the wait ends with `done`, `timed_out` set to 1 and `status_out` holding the last status byte. The wait never ends with a timeout before the deadline.
- R6: A `start` pulse that arrives while a wait is in progress has no effect on the operation kind or the timing of that wait.
- R7: Once `desc_valid` is high, it stays high with the same fields until `desc_ready` is seen. Only one request is outstanding at a time: `desc_valid` is low while the poller waits for a response.
- R8: After reset, `done`, `desc_valid` and `timed_out` are 0 and `status_out` is 0x00.
- R9: `done` is a single-cycle pulse. `status_out` and `timed_out` hold their values after it until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a wait (accepted only when idle) |
| op_sel | input | 2 | Operation kind: 0 read, 1 program, 2 erase, 3 reset |
| done | output | 1 | One-cycle pulse when the wait ends |
| status_out | output | 8 | Last status byte read |
| timed_out | output | 1 | Wait ended on the deadline |
| desc_valid | output | 1 | Status-read request to the frame engine |
| desc_ready | input | 1 | Frame engine accepts the request |
| desc_opcode | output | 8 | Command opcode of the request |
| desc_regaddr | output | 8 | Register address of the request |
| rsp_valid | input | 1 | Status byte returned by the frame engine |
| rsp_byte | input | 8 | Returned status byte |

## Verification
The bench runs a small configuration with two cycles per microsecond and a short deadline. Every operation kind is combined with zero, one and two busy responses before the ready one, so the settle and gap timing is measured for each kind. A wrong entry in the delay table, or a swap between the settle value and the gap value, shows up as a timing mismatch.

Further runs cover the following cases:
- A frame engine that stalls the request, which tests how the request is held.
- A second `start` pulse during a busy gap, which must leave the timing of the running wait unchanged.
- A device that never becomes ready, which must end on the deadline window and no earlier. The following run must clear the timeout flag.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_PROGRAM = 2'd1,
        OP_ERASE   = 2'd2,
        OP_RESET   = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_GAP,
        ST_DONE
    } poll_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] reg_addr;
    } reg_frame_t;

    localparam logic [7:0] GETREG_OPCODE   = 8'h0F;
    localparam logic [7:0] STATUS_REG_ADDR = 8'hC0;
    localparam int         BUSY_BIT        = 0;

    localparam reg_frame_t STATUS_FRAME = '{opcode: GETREG_OPCODE, reg_addr: STATUS_REG_ADDR};

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fbp_delay_sel.sv
module fbp_delay_sel
    import fbp_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 50,
    parameter int unsigned RD_INIT_US = 6,
    parameter int unsigned RD_POLL_US = 5,
    parameter int unsigned PG_INIT_US = 75,
    parameter int unsigned PG_POLL_US = 15,
    parameter int unsigned ER_INIT_US = 250,
    parameter int unsigned ER_POLL_US = 50,
    parameter int unsigned RS_INIT_US = 5,
    parameter int unsigned RS_POLL_US = 5,
    parameter int unsigned W          = 16
) (
    input  op_kind_e       op,
    output logic [W-1:0]   init_cyc,
    output logic [W-1:0]   poll_cyc
);
    localparam logic [W-1:0] RD_INIT_C = W'(RD_INIT_US * CYC_PER_US);
    localparam logic [W-1:0] RD_POLL_C = W'(RD_POLL_US * CYC_PER_US);
    localparam logic [W-1:0] PG_INIT_C = W'(PG_INIT_US * CYC_PER_US);
    localparam logic [W-1:0] PG_POLL_C = W'(PG_POLL_US * CYC_PER_US);
    localparam logic [W-1:0] ER_INIT_C = W'(ER_INIT_US * CYC_PER_US);
    localparam logic [W-1:0] ER_POLL_C = W'(ER_POLL_US * CYC_PER_US);
    localparam logic [W-1:0] RS_INIT_C = W'(RS_INIT_US * CYC_PER_US);
    localparam logic [W-1:0] RS_POLL_C = W'(RS_POLL_US * CYC_PER_US);

    always_comb begin
        unique case (op)
            OP_READ:    begin init_cyc = RD_INIT_C; poll_cyc = RD_POLL_C; end
            OP_PROGRAM: begin init_cyc = PG_INIT_C; poll_cyc = PG_POLL_C; end
            OP_ERASE:   begin init_cyc = ER_INIT_C; poll_cyc = ER_POLL_C; end
            default:    begin init_cyc = RS_INIT_C; poll_cyc = RS_POLL_C; end
        endcase
    end
endmodule

// File: rtl/fbp_interval_timer.sv
module fbp_interval_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R3
    interval_count_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !expired) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/fbp_deadline.sv
module fbp_deadline #(
    parameter int unsigned LIMIT = 1000,
    parameter int unsigned W     = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic hit
);
    logic [W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            elapsed <= '0;
        end else if (run && !hit) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign hit = (elapsed == W'(LIMIT));

    // R5
    deadline_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !clear) |=> hit);
endmodule

// File: rtl/flash_busy_poller.sv
module flash_busy_poller
    import fbp_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 50,
    parameter int unsigned RD_INIT_US = 6,
    parameter int unsigned RD_POLL_US = 5,
    parameter int unsigned PG_INIT_US = 75,
    parameter int unsigned PG_POLL_US = 15,
    parameter int unsigned ER_INIT_US = 250,
    parameter int unsigned ER_POLL_US = 50,
    parameter int unsigned RS_INIT_US = 5,
    parameter int unsigned RS_POLL_US = 5,
    parameter int unsigned TIMEOUT_US = 400000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] op_sel,
    output logic       done,
    output logic [7:0] status_out,
    output logic       timed_out,
    output logic       desc_valid,
    input  logic       desc_ready,
    output logic [7:0] desc_opcode,
    output logic [7:0] desc_regaddr,
    input  logic       rsp_valid,
    input  logic [7:0] rsp_byte
);
    localparam int unsigned MAX_US  = max_u(max_u(max_u(RD_INIT_US, RD_POLL_US), max_u(PG_INIT_US, PG_POLL_US)),
                                            max_u(max_u(ER_INIT_US, ER_POLL_US), max_u(RS_INIT_US, RS_POLL_US)));
    localparam int unsigned MAX_CYC = MAX_US * CYC_PER_US;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam int unsigned TMO_CYC = TIMEOUT_US * CYC_PER_US;
    localparam int unsigned TMO_W   = $clog2(TMO_CYC + 1);

    poll_state_e      state;
    op_kind_e         op_q;
    op_kind_e         op_lookup;
    logic [7:0]       status_q;
    logic             tmo_q;
    logic [CNT_W-1:0] init_cyc;
    logic [CNT_W-1:0] poll_cyc;
    logic             accept;
    logic             busy_rsp;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_run;
    logic             tmr_expired;
    logic             deadline_hit;

    assign accept    = (state == ST_IDLE) && start;
    assign busy_rsp  = (state == ST_AWAIT) && rsp_valid && rsp_byte[BUSY_BIT];
    assign op_lookup = (state == ST_IDLE) ? op_kind_e'(op_sel) : op_q;
    assign tmr_load  = accept || busy_rsp;
    assign tmr_val   = accept ? init_cyc : poll_cyc;
    assign tmr_run   = (state == ST_SETTLE) || (state == ST_GAP);

    fbp_delay_sel #(
        .CYC_PER_US(CYC_PER_US),
        .RD_INIT_US(RD_INIT_US), .RD_POLL_US(RD_POLL_US),
        .PG_INIT_US(PG_INIT_US), .PG_POLL_US(PG_POLL_US),
        .ER_INIT_US(ER_INIT_US), .ER_POLL_US(ER_POLL_US),
        .RS_INIT_US(RS_INIT_US), .RS_POLL_US(RS_POLL_US),
        .W(CNT_W)
    ) delay_sel_i (
        .op       (op_lookup),
        .init_cyc (init_cyc),
        .poll_cyc (poll_cyc)
    );

    fbp_interval_timer #(.W(CNT_W)) interval_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .expired  (tmr_expired)
    );

    fbp_deadline #(.LIMIT(TMO_CYC), .W(TMO_W)) deadline_i (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .run   (state != ST_IDLE),
        .hit   (deadline_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op_q     <= OP_READ;
            status_q <= 8'h00;
            tmo_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q     <= op_kind_e'(op_sel);
                        status_q <= 8'h00;
                        tmo_q    <= 1'b0;
                        state    <= ST_SETTLE;
                    end
                end
                ST_SETTLE, ST_GAP: begin
                    if (deadline_hit) begin
                        tmo_q <= 1'b1;
                        state <= ST_DONE;
                    end else if (tmr_expired) begin
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (desc_ready) state <= ST_AWAIT;
                end
                ST_AWAIT: begin
                    if (rsp_valid) begin
                        status_q <= rsp_byte;
                        if (!rsp_byte[BUSY_BIT]) begin
                            state <= ST_DONE;
                        end else if (deadline_hit) begin
                            tmo_q <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            state <= ST_GAP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done         = (state == ST_DONE);
    assign status_out   = status_q;
    assign timed_out    = tmo_q;
    assign desc_valid   = (state == ST_ISSUE);
    assign desc_opcode  = STATUS_FRAME.opcode;
    assign desc_regaddr = STATUS_FRAME.reg_addr;

    // R4
    ready_end_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AWAIT && rsp_valid && !rsp_byte[BUSY_BIT])
            |=> (done && !timed_out && status_out == $past(rsp_byte)));

    // R5
    tmo_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (done && timed_out) |-> deadline_hit);

    // R6
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AWAIT && start && !rsp_valid) |=> (state == ST_AWAIT && op_q == $past(op_q)));

    // R7
    desc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_opcode) && $stable(desc_regaddr)));

    // R7
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_ready) |=> !desc_valid);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && $stable(status_out) && $stable(timed_out)));
endmodule

// File: tb/flash_busy_poller_tb_top.sv
module flash_busy_poller_tb_top;
    localparam int CYC = 2;
    localparam int TMO_US = 600;
    localparam int TMO_CYC = TMO_US * CYC;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic       done;
    logic [7:0] status_out;
    logic       timed_out;
    logic       desc_valid;
    logic       desc_ready = 1'b1;
    logic [7:0] desc_opcode;
    logic [7:0] desc_regaddr;
    logic       rsp_valid = 1'b0;
    logic [7:0] rsp_byte = 8'h00;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_busy_poller #(.CYC_PER_US(CYC), .TIMEOUT_US(TMO_US)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
        .done(done), .status_out(status_out), .timed_out(timed_out),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_opcode(desc_opcode), .desc_regaddr(desc_regaddr),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
    );

    function automatic int settle_cyc(input int op);
        case (op)
            0: return 6 * CYC;
            1: return 75 * CYC;
            2: return 250 * CYC;
            default: return 5 * CYC;
        endcase
    endfunction

    function automatic int gap_cyc(input int op);
        case (op)
            0: return 5 * CYC;
            1: return 15 * CYC;
            2: return 50 * CYC;
            default: return 5 * CYC;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // One wait: nbusy busy replies then a ready one.
    task automatic run_op(input int op, input int nbusy, input int stall, input bit inject);
        int t0;
        int tref;
        int t;
        logic [7:0] b;
        @(negedge clk);
        start = 1'b1; op_sel = 2'(op); t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        tref = t0;
        for (int k = 0; k <= nbusy; k++) begin
            while (!desc_valid) @(negedge clk);
            t = cyc;
            if (k == 0)
                check(t - tref == settle_cyc(op) + 1, "R2 settle", t - tref, settle_cyc(op) + 1);
            else
                check(t - tref == gap_cyc(op) + 1, "R3 gap", t - tref, gap_cyc(op) + 1);
            check(desc_opcode == 8'h0F && desc_regaddr == 8'hC0, "R1 fields",
                  {desc_opcode, desc_regaddr}, 16'h0FC0);
            if (stall > 0) begin
                desc_ready = 1'b0;
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    check(desc_valid && desc_opcode == 8'h0F, "R7 hold", desc_valid, 1);
                end
                desc_ready = 1'b1;
            end
            @(negedge clk);
            check(!desc_valid, "R7 single", desc_valid, 0);
            repeat (LAT - 1) @(negedge clk);
            b = (k < nbusy) ? (8'h01 | 8'(k << 4) | 8'(op << 2)) : (8'hA0 | 8'(op << 1));
            rsp_valid = 1'b1; rsp_byte = b; tref = cyc;
            @(negedge clk);
            rsp_valid = 1'b0;
            if (k < nbusy) begin
                check(!done, "R3 busy continues", done, 0);
                if (inject && k == 0) begin
                    start = 1'b1; op_sel = 2'(op ^ 2);
                    @(negedge clk);
                    start = 1'b0;
                end
            end else begin
                check(done == 1'b1, "R4 done", done, 1);
                check(status_out == b, "R4 status", status_out, b);
                check(!timed_out, "R4 no timeout", timed_out, 0);
                @(negedge clk);
                check(!done, "R9 pulse", done, 0);
                check(status_out == b && !timed_out, "R9 held", status_out, b);
            end
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        int t0;
        int e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8
        check(!done, "R8 done", done, 0);
        check(!desc_valid, "R8 desc_valid", desc_valid, 0);
        check(!timed_out, "R8 timed_out", timed_out, 0);
        check(status_out == 8'h00, "R8 status", status_out, 0);

        for (int op = 0; op < 4; op++)
            for (int nb = 0; nb < 3; nb++)
                run_op(op, nb, 0, 1'b0);

        run_op(1, 1, 4, 1'b0);   // R7 stalled request
        run_op(0, 2, 0, 1'b1);   // R6 start during a busy gap

        // R5: device never ready
        @(negedge clk);
        start = 1'b1; op_sel = 2'd3; t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        while (!done) begin
            if (desc_valid) begin
                @(negedge clk);
                repeat (LAT - 1) @(negedge clk);
                rsp_valid = 1'b1; rsp_byte = 8'h41;
                @(negedge clk);
                rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        e = cyc - (t0 + 1);
        check(timed_out == 1'b1, "R5 flag", timed_out, 1);
        check(status_out == 8'h41, "R5 last status", status_out, 8'h41);
        check(e >= TMO_CYC + 1, "R5 not early", e, TMO_CYC + 1);
        check(e <= TMO_CYC + gap_cyc(3) + LAT + 4, "R5 not late", e, TMO_CYC + gap_cyc(3) + LAT + 4);
        @(negedge clk);
        check(timed_out == 1'b1 && !done, "R9 timeout held", timed_out, 1);

        run_op(2, 0, 0, 1'b0);   // timeout flag clears on a new wait
        summary();
    end
endmodule